// File: doc/BRIEF.md
# Folded Four-Tap FIR Filter

This block is a sequential four-tap FIR filter that produces one filtered output per start request. Instead of four multipliers it reuses one multiply-accumulate lane (or two lanes in the dual-read option) over several cycles. It keeps its own four-entry history of past samples. Its coefficients live in an external memory that the block reads through address and chip-enable ports, with one cycle from address to data.

A computation clears the accumulator and then walks the taps from index 3 down to index 0. At each tap above zero it moves history entry i-1 into entry i and accumulates that value times coefficient i. At tap 0 it multiplies the incoming sample by coefficient 0 and stores the sample as the newest history entry. The sum is written to the output once, together with a one-cycle done pulse. The incoming sample is read only at the tap-0 step, so a producer may present it late. With the dual-read option set, the block fetches two coefficients per cycle on two memory ports and retires two taps per cycle.

Top module: `fir4_folded`

## Requirements
- R1: After reset, busy_o, done_o, result_o and both chip enables are 0, and the sample history is all zero, so the first result equals sample times coefficient 0.
- R2: Each result equals c0*x + c1*h0 + c2*h1 + c3*h2, where x is the new sample, h0 is the most recent earlier sample, h1 the one before, and so on. ck is the signed memory word at address k. After the computation the history has shifted by one and x is the newest entry.
- R3: The accumulator is cleared at every accepted start, so a result never includes anything from an earlier computation.
- R4: With a single read port, addresses 3, 2, 1, 0 are issued on coef_addr_a_o with coef_ce_a_o high in the four cycles that follow the start edge, coef_ce_b_o stays 0, and done_o rises 5 cycles after the edge that accepted start.
- R5: With dual reads, port A issues addresses 3 then 1 and port B issues 2 then 0, both enables high in the two cycles after the start edge, and done_o rises 3 cycles after that edge.
- R6: A start_i seen while busy_o is high is ignored: it issues no coefficient reads, produces no extra done pulse and does not shift the history.
- R7: done_o is high for exactly one cycle, and result_o keeps its value until the next done pulse.
- R8: sample_i is read only at the clock edge that completes the computation (the edge at which done_o rises). Its value in any other cycle has no effect.
- R9: Products and sums are signed, and the accumulator (DATA_W+COEF_W+2 bits) holds four full-scale products without overflow. With every operand at the most negative value, the result is +2^32 for 16-bit operands.
- R10: busy_o is high from the cycle after an accepted start up to the cycle before done_o, and is low in the cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one computation; taken only when idle |
| sample_i | input | DATA_W | New signed input sample, read at the final tap step |
| coef_addr_a_o | output | 2 | Coefficient memory address, port A |
| coef_ce_a_o | output | 1 | Coefficient memory read enable, port A |
| coef_data_a_i | input | COEF_W | Signed coefficient returned one cycle after an A read |
| coef_addr_b_o | output | 2 | Coefficient memory address, port B (dual-read option only) |
| coef_ce_b_o | output | 1 | Coefficient memory read enable, port B |
| coef_data_b_i | input | COEF_W | Signed coefficient returned one cycle after a B read |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse marking a new result |
| result_o | output | ACC_W | Signed filter output |

## Verification
The assertions assume that the coefficient memory answers every enabled read with data in the next cycle. They also assume that reset is applied before the first start request. The bench models the memory with exactly that one-cycle registered read and changes coefficients only while the block is idle. The assertions on address order and latency assume that start_i is never asserted during reset. The bench raises start only on falling edges after reset has been released, and it pulses start during a busy run only to exercise the ignore rule.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
  localparam int NTAPS  = 4;
  localparam int ADDR_W = $clog2(NTAPS);
  localparam int GRP_W  = 2;
endpackage

// File: rtl/fir4_ctrl.sv
module fir4_ctrl
  import fir4_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              busy_o,
  output logic              clr_o,
  output logic              rd_ce_o,
  output logic [ADDR_W-1:0] rd_addr_o [LANES],
  output logic              mac_act_o,
  output logic              mac_last_o,
  output logic [GRP_W-1:0]  mac_grp_o
);
  localparam int NSTEP = NTAPS / LANES;
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NSTEP - 1);

  logic             fetch_act;
  logic [GRP_W-1:0] fetch_grp;
  logic             mac_act;
  logic [GRP_W-1:0] mac_grp;
  logic             accept;

  assign busy_o = fetch_act | mac_act;
  assign accept = start_i & ~busy_o;
  assign clr_o  = accept;

  // fetch stage issues reads; mac stage consumes data one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_act <= 1'b0;
      fetch_grp <= '0;
      mac_act   <= 1'b0;
      mac_grp   <= '0;
    end else begin
      mac_act <= fetch_act;
      mac_grp <= fetch_grp;
      if (accept) begin
        fetch_act <= 1'b1;
        fetch_grp <= '0;
      end else if (fetch_act) begin
        if (fetch_grp == LAST_GRP) fetch_act <= 1'b0;
        else                       fetch_grp <= fetch_grp + 1'b1;
      end
    end
  end

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_addr
      assign rd_addr_o[l] = ADDR_W'(NTAPS - 1 - int'(fetch_grp) * LANES - l);
    end
  endgenerate

  assign rd_ce_o    = fetch_act;
  assign mac_act_o  = mac_act;
  assign mac_grp_o  = mac_grp;
  assign mac_last_o = mac_act & (mac_grp == LAST_GRP);
endmodule

// File: rtl/fir4_datapath.sv
module fir4_datapath
  import fir4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = DATA_W + COEF_W + 2,
  parameter int LANES  = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_i,
  input  logic                     mac_act_i,
  input  logic                     mac_last_i,
  input  logic [GRP_W-1:0]         mac_grp_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [COEF_W-1:0] coef_i [LANES],
  output logic signed [ACC_W-1:0]  result_o,
  output logic                     done_o
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [DATA_W-1:0] hist [NTAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  acc_next;
  logic [ADDR_W-1:0]        tap  [LANES];
  logic signed [DATA_W-1:0] src  [LANES];
  logic signed [PROD_W-1:0] prod [LANES];

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign tap[l]  = ADDR_W'(NTAPS - 1 - int'(mac_grp_i) * LANES - l);
      // tap 0 takes the fresh sample, others take the next-younger entry
      assign src[l]  = (tap[l] == '0) ? sample_i : hist[tap[l] - 1'b1];
      assign prod[l] = src[l] * coef_i[l];
    end
  endgenerate

  always_comb begin
    acc_next = acc;
    for (int i = 0; i < LANES; i++) begin
      acc_next = acc_next + {{(ACC_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) hist[i] <= '0;
      acc      <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) begin
        acc <= '0;
      end else if (mac_act_i) begin
        acc <= acc_next;
        for (int i = 0; i < LANES; i++) hist[tap[i]] <= src[i];
        if (mac_last_i) begin
          result_o <= acc_next;
          done_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fir4_folded.sv
module fir4_folded
  import fir4_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int DUAL_PORT = 0,
  parameter int ACC_W     = DATA_W + COEF_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic [1:0]               coef_addr_a_o,
  output logic                     coef_ce_a_o,
  input  logic signed [COEF_W-1:0] coef_data_a_i,
  output logic [1:0]               coef_addr_b_o,
  output logic                     coef_ce_b_o,
  input  logic signed [COEF_W-1:0] coef_data_b_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic signed [ACC_W-1:0]  result_o
);
  localparam int LANES = (DUAL_PORT != 0) ? 2 : 1;

  logic              clr;
  logic              rd_ce;
  logic [ADDR_W-1:0] rd_addr [LANES];
  logic              mac_act;
  logic              mac_last;
  logic [GRP_W-1:0]  mac_grp;
  logic signed [COEF_W-1:0] coef [LANES];

  fir4_ctrl #(.LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .clr_o      (clr),
    .rd_ce_o    (rd_ce),
    .rd_addr_o  (rd_addr),
    .mac_act_o  (mac_act),
    .mac_last_o (mac_last),
    .mac_grp_o  (mac_grp)
  );

  assign coef_addr_a_o = rd_addr[0];
  assign coef_ce_a_o   = rd_ce;
  assign coef[0]       = coef_data_a_i;

  generate
    if (LANES == 2) begin : g_dual
      assign coef_addr_b_o = rd_addr[1];
      assign coef_ce_b_o   = rd_ce;
      assign coef[1]       = coef_data_b_i;
    end else begin : g_single
      assign coef_addr_b_o = '0;
      assign coef_ce_b_o   = 1'b0;
    end
  endgenerate

  fir4_datapath #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W),
    .LANES  (LANES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .mac_act_i  (mac_act),
    .mac_last_i (mac_last),
    .mac_grp_i  (mac_grp),
    .sample_i   (sample_i),
    .coef_i     (coef),
    .result_o   (result_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/fir4_folded_chk.sv
module fir4_folded_chk #(
  parameter int DUAL_PORT = 0,
  parameter int ACC_W     = 34
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [ACC_W-1:0] result_o,
  input logic             coef_ce_a_o,
  input logic [1:0]       coef_addr_a_o
);
  localparam int LANES = (DUAL_PORT != 0) ? 2 : 1;
  localparam int LAT   = 4 / LANES + 1;

  logic [3:0] since_start;
  always_ff @(posedge clk) begin
    if (rst)                         since_start <= '0;
    else if (start_i && !busy_o)     since_start <= '0;
    else if (busy_o)                 since_start <= since_start + 1'b1;
  end

  // R4 / R5: done arrives a fixed number of cycles after an accepted start
  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (since_start == 4'(LAT)));

  // R4 / R5: consecutive reads walk the taps downward
  assert_addr_descend_R4: assert property (@(posedge clk) disable iff (rst)
    (coef_ce_a_o && $past(coef_ce_a_o)) |-> (coef_addr_a_o == ($past(coef_addr_a_o) - 2'(LANES))));

  assert_fetch_on_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(coef_ce_a_o) |-> $past(start_i && !busy_o));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

bind fir4_folded fir4_folded_chk #(
  .DUAL_PORT (DUAL_PORT),
  .ACC_W     (ACC_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .result_o      (result_o),
  .coef_ce_a_o   (coef_ce_a_o),
  .coef_addr_a_o (coef_addr_a_o)
);

// File: tb/fir4_folded_tb.sv
`timescale 1ns/1ps
module fir4_folded_tb;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int AW = DW + CW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // index 0: single read port (u_dut), index 1: dual read (u_dut_dp)
  logic                 start  [2];
  logic signed [DW-1:0] smp    [2];
  logic [1:0]           addr_a [2];
  logic [1:0]           addr_b [2];
  logic                 ce_a   [2];
  logic                 ce_b   [2];
  logic signed [CW-1:0] rd_a   [2];
  logic signed [CW-1:0] rd_b   [2];
  logic                 busy   [2];
  logic                 done   [2];
  logic signed [AW-1:0] res    [2];

  logic signed [CW-1:0] cm [4];
  longint hist [2][4];
  int nvec = 0;
  int nfail = 0;

  fir4_folded #(.DATA_W(DW), .COEF_W(CW), .DUAL_PORT(0)) u_dut (
    .clk(clk), .rst(rst), .start_i(start[0]), .sample_i(smp[0]),
    .coef_addr_a_o(addr_a[0]), .coef_ce_a_o(ce_a[0]), .coef_data_a_i(rd_a[0]),
    .coef_addr_b_o(addr_b[0]), .coef_ce_b_o(ce_b[0]), .coef_data_b_i(rd_b[0]),
    .busy_o(busy[0]), .done_o(done[0]), .result_o(res[0]));

  fir4_folded #(.DATA_W(DW), .COEF_W(CW), .DUAL_PORT(1)) u_dut_dp (
    .clk(clk), .rst(rst), .start_i(start[1]), .sample_i(smp[1]),
    .coef_addr_a_o(addr_a[1]), .coef_ce_a_o(ce_a[1]), .coef_data_a_i(rd_a[1]),
    .coef_addr_b_o(addr_b[1]), .coef_ce_b_o(ce_b[1]), .coef_data_b_i(rd_b[1]),
    .busy_o(busy[1]), .done_o(done[1]), .result_o(res[1]));

  // coefficient memories with one-cycle registered read
  for (genvar d = 0; d < 2; d++) begin : g_mem
    always_ff @(posedge clk) begin
      if (ce_a[d]) rd_a[d] <= cm[addr_a[d]];
      if (ce_b[d]) rd_b[d] <= cm[addr_b[d]];
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_coefs(input int c0, input int c1, input int c2, input int c3);
    cm[0] = CW'(c0); cm[1] = CW'(c1); cm[2] = CW'(c2); cm[3] = CW'(c3);
  endtask

  // one computation on DUT d, checking reads, latency, busy, done and result
  task automatic run_op(input int d, input int s, input bit late, input bit poke);
    int ns = (d == 0) ? 4 : 2;
    int ln = (d == 0) ? 1 : 2;
    string tl = (d == 0) ? "R4" : "R5";
    longint expv = longint'(cm[0]) * s + longint'(cm[1]) * hist[d][0]
                 + longint'(cm[2]) * hist[d][1] + longint'(cm[3]) * hist[d][2];
    @(negedge clk);
    start[d] = 1'b1;
    smp[d]   = late ? 16'sh5A5A : DW'(s);
    @(negedge clk);
    start[d] = poke;
    chk("R10 busy after start", longint'(busy[d]), 1);
    chk({tl, " first read enable"}, longint'(ce_a[d]), 1);
    chk({tl, " first address A"}, longint'(addr_a[d]), 3);
    chk({tl, " port B enable"}, longint'(ce_b[d]), (d == 1) ? 1 : 0);
    if (d == 1) chk("R5 first address B", longint'(addr_b[d]), 2);
    for (int k = 1; k <= ns; k++) begin
      @(negedge clk);
      start[d] = 1'b0;
      if (k < ns) begin
        chk({tl, " read enable A"}, longint'(ce_a[d]), 1);
        chk({tl, " address A"}, longint'(addr_a[d]), 3 - k * ln);
        if (d == 1) chk("R5 address B", longint'(addr_b[d]), 2 - 2 * k);
        else        chk("R4 port B idle", longint'(ce_b[d]), 0);
      end else begin
        chk({tl, " reads finished"}, longint'(ce_a[d]), 0);
      end
      chk({tl, " done not early"}, longint'(done[d]), 0);
      chk("R10 busy during run", longint'(busy[d]), 1);
      if (late && k == ns) smp[d] = DW'(s);
    end
    @(negedge clk);
    chk({tl, " done latency"}, longint'(done[d]), 1);
    chk("R2 result", longint'(res[d]), expv);
    chk("R10 idle at done", longint'(busy[d]), 0);
    if (late) smp[d] = 16'sh7E7E;
    @(negedge clk);
    chk("R7 done single pulse", longint'(done[d]), 0);
    chk("R7 result held", longint'(res[d]), expv);
    chk("R6 no extra read", longint'(ce_a[d]), 0);
    hist[d][3] = hist[d][2];
    hist[d][2] = hist[d][1];
    hist[d][1] = hist[d][0];
    hist[d][0] = s;
  endtask

  task automatic test_reset();
    for (int d = 0; d < 2; d++) begin
      chk("R1 busy after reset", longint'(busy[d]), 0);
      chk("R1 done after reset", longint'(done[d]), 0);
      chk("R1 result after reset", longint'(res[d]), 0);
      chk("R1 enable after reset", longint'(ce_a[d]) + longint'(ce_b[d]), 0);
    end
  endtask

  task automatic test_first_and_stream();
    load_coefs(3, -5, 7, 2);
    for (int d = 0; d < 2; d++) begin
      run_op(d, 100, 1'b0, 1'b0);   // R1: empty history, so result = 3*100
      run_op(d, -40, 1'b0, 1'b0);   // R3: accumulator restarted
      run_op(d, 1234, 1'b0, 1'b0);
      run_op(d, 9, 1'b0, 1'b0);
      run_op(d, -32000, 1'b0, 1'b0);
    end
  endtask

  task automatic test_coef_change();
    load_coefs(-1, 11, 0, -300);
    for (int d = 0; d < 2; d++) begin
      run_op(d, 500, 1'b0, 1'b0);
      run_op(d, -7, 1'b0, 1'b0);
    end
  endtask

  task automatic test_late_sample();
    load_coefs(21, -4, 13, 6);
    for (int d = 0; d < 2; d++) begin
      run_op(d, 777, 1'b1, 1'b0);   // R8
      run_op(d, -55, 1'b1, 1'b0);   // R8
    end
  endtask

  task automatic test_start_ignored();
    load_coefs(2, 3, 5, 7);
    for (int d = 0; d < 2; d++) begin
      run_op(d, 10, 1'b0, 1'b1);    // R6: start pulsed mid-run
      run_op(d, 20, 1'b0, 1'b0);    // R6: history shifted exactly once
    end
  endtask

  task automatic test_extremes();
    load_coefs(-32768, -32768, -32768, -32768);
    for (int d = 0; d < 2; d++) begin
      for (int n = 0; n < 4; n++) run_op(d, -32768, 1'b0, 1'b0);
      chk("R9 full-scale sum", longint'(res[d]), 64'sd4294967296);
    end
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      start[d] = 1'b0;
      smp[d]   = '0;
      for (int t = 0; t < 4; t++) hist[d][t] = 0;
    end
    load_coefs(0, 0, 0, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_first_and_stream();
    test_coef_change();
    test_late_sample();
    test_start_ignored();
    test_extremes();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule